// File: doc/BRIEF.md
# Priority region access firewall

This block decides, for every bus request, whether the access may go ahead. The checks use a set of programmable address regions. Each region holds a start page, an end page, one enable bit per input port and a two-bit rights field. Region 0 is a background region that covers the whole address space, so it supplies the default rights. Any other region that covers the request page and is enabled for the requesting port takes precedence over every lower-numbered region. The rights of the highest-numbered matching region decide the outcome.

A request carries its page number (address bits [33:12]), a write flag and an initiator ID. One cycle later the block returns an allow/deny result, the index of the winning region and the echoed ID. The block can be built with one or two ports and up to sixteen regions. A shift setting lets the 32-bit boundary registers describe a 16 GiB target. In that mode software writes each boundary address shifted right by two bits, so the 34-bit address 0x3_0000_0000 is written as 0xC000_0000.

Configuration goes through a simple write port into shadow copies. A single control write copies all shadow copies, together with the new shift setting, into the active set in one step. A request is therefore never checked against a half-written region.

Top module: `region_firewall`

## Requirements
- R1: A request presented with `reqValid` in cycle t yields `rspValid`=1 with `rspAllow`, `rspRegion` and `rspId` (the echoed `reqId`) in cycle t+1. In any cycle that follows a cycle without a request, `rspValid` and `rspAllow` are 0.
- R2: Region 0 matches every page on every port. When no other region matches, `rspRegion` is 0 and region 0's rights apply.
- R3: Region i (i ≥ 1) covers a request when start page ≤ request page ≤ end page, both bounds inclusive. With shift 0, register bits [31:12] are compared with address bits [31:12]. Register bits [11:0] and address bits [33:32] take no part in the comparison.
- R4: When several enabled regions cover a request, the one with the highest index wins.
- R5: The rights field, written at field code 2, has bit 0 = read permitted and bit 1 = write permitted. `rspAllow` is 1 only if the winner permits the requested direction (`reqWrite`=1 means write).
- R6: Bit p of a region's end register enables that region for port p. A region whose bit is clear is never matched by requests on that port.
- R7: Control value 2 selects shift mode. In that mode register bits [31:10] are compared with address bits [33:12] and register bits [9:0] are ignored.
- R8: Writes to start (field 0), end (field 1) and rights (field 2) reach only shadow copies. A write to field 3 copies every shadow copy to the active set and loads the shift from data [1:0], all on the same edge. Until then, checks use the old settings.
- R9: After reset every region i ≥ 1 is disabled on all ports, region 0 has no rights, and the shift is 0. Every request is therefore denied by region 0.
- R10: A configuration write whose region index (`cfgAddr[5:2]`) is not below the region count has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgAddr | input | 6 | {region index[3:0], field code[1:0]}; field 0 start, 1 end, 2 rights, 3 control/commit |
| cfgWrData | input | 32 | Configuration write data |
| reqValid | input | NUM_PORTS | Request present, one bit per port |
| reqPage | input | NUM_PORTS*22 | Request address bits [33:12], per port |
| reqWrite | input | NUM_PORTS | 1 = write, 0 = read, per port |
| reqId | input | NUM_PORTS*ID_W | Initiator ID, per port |
| rspValid | output | NUM_PORTS | Result present, per port |
| rspAllow | output | NUM_PORTS | 1 = access allowed, per port |
| rspRegion | output | NUM_PORTS*IDXW | Index of the winning region, per port |
| rspId | output | NUM_PORTS*ID_W | Echoed initiator ID, per port |

## Verification
The main check runs over a fixed layout of four regions. Region 1 is wide, region 2 is a single page nested inside it, and region 5 overlaps region 1 only on port 1. Probes hit both edges of each range, the pages just outside them, pages that differ only in the two ignored upper bits, and the same page on both ports in one cycle. These probes separate wrong priority order, inclusive from exclusive bounds, missing per-port masking and mixed-up rights bits. A second pass switches to shift mode and reuses the same register values. The same pages then land in different regions, which exposes a wrong bit alignment. Directed probes issued between shadow writes and the commit separate atomic update from write-through.

// File: rtl/region_fw_pkg.sv
package region_fw_pkg;

  localparam int unsigned CfgRegionW = 4;
  localparam int unsigned PageW      = 22;

  typedef enum logic [1:0] {
    FLD_START  = 2'd0,
    FLD_END    = 2'd1,
    FLD_RIGHTS = 2'd2,
    FLD_CTRL   = 2'd3
  } cfgField_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic                  shadowWr;
    cfgField_e             field;
    logic [CfgRegionW-1:0] region;
    logic                  commit;
    logic [1:0]            shift;
    logic [31:0]           data;
  } fwStrobes_t;

  // Boundary register -> page number in the firewall space
  function automatic logic [PageW-1:0] regToPage(input logic [31:0] value,
                                                 input logic [1:0]  shift);
    logic [PageW-1:0] pg;
    case (shift)
      2'd0:    pg = {2'b00, value[31:12]};
      2'd1:    pg = {1'b0, value[31:11]};
      default: pg = value[31:10];
    endcase
    return pg;
  endfunction

  // Request page with the unused upper bits masked off for the mode
  function automatic logic [PageW-1:0] maskPage(input logic [PageW-1:0] page,
                                                input logic [1:0]       shift);
    logic [PageW-1:0] pg;
    case (shift)
      2'd0:    pg = {2'b00, page[19:0]};
      2'd1:    pg = {1'b0, page[20:0]};
      default: pg = page;
    endcase
    return pg;
  endfunction

endpackage

// File: rtl/region_fw_ctrl.sv
module region_fw_ctrl
  import region_fw_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8
) (
  input  logic        cfgWrEn,
  input  logic [5:0]  cfgAddr,
  input  logic [31:0] cfgWrData,
  output fwStrobes_t  strb
);

  localparam logic [CfgRegionW:0] RegionLimit = (CfgRegionW+1)'(NUM_REGIONS);

  cfgField_e             field;
  logic [CfgRegionW-1:0] regionSel;
  logic                  regionOk;

  assign field     = cfgField_e'(cfgAddr[1:0]);
  assign regionSel = cfgAddr[5:2];
  assign regionOk  = {1'b0, regionSel} < RegionLimit;

  always_comb begin
    strb          = '0;
    strb.field    = field;
    strb.region   = regionSel;
    strb.data     = cfgWrData;
    strb.shift    = cfgWrData[1:0];
    strb.shadowWr = cfgWrEn && (field != FLD_CTRL) && regionOk;
    strb.commit   = cfgWrEn && (field == FLD_CTRL);
  end

endmodule

// File: rtl/region_fw_port_check.sv
module region_fw_port_check
  import region_fw_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned PORT        = 0,
  parameter int unsigned IDXW        = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_REGIONS-1:0][31:0] actStart,
  input  logic [NUM_REGIONS-1:0][31:0] actEnd,
  input  logic [NUM_REGIONS-1:0][1:0]  actRights,
  input  logic [1:0]                  actShift,
  input  logic [PageW-1:0]            reqPage,
  input  logic                        reqWrite,
  output logic [IDXW-1:0]             winIdx,
  output logic                        allow
);

  logic [1:0]       effShift;
  logic [PageW-1:0] pg;

  assign effShift = (actShift == 2'd3) ? 2'd2 : actShift;
  assign pg       = maskPage(reqPage, effShift);

  // Ascending scan: a later hit overrides, so the top index wins
  always_comb begin
    logic [PageW-1:0] lo, hi;
    logic             hit;
    winIdx = '0;
    lo     = '0;
    hi     = '0;
    hit    = 1'b0;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      lo  = regToPage(actStart[i], effShift);
      hi  = regToPage(actEnd[i], effShift);
      hit = (i == 0) || (actEnd[i][PORT] && (lo <= pg) && (pg <= hi));
      if (hit) winIdx = IDXW'(i);
    end
  end

  assign allow = reqWrite ? actRights[winIdx][1] : actRights[winIdx][0];

  AST_WINNER_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    (winIdx != '0) |-> actEnd[winIdx][PORT]); // R6

endmodule

// File: rtl/region_fw_datapath.sv
module region_fw_datapath
  import region_fw_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned NUM_PORTS   = 2,
  parameter int unsigned ID_W        = 4,
  parameter int unsigned IDXW        = 3
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  fwStrobes_t                       strb,
  input  logic [NUM_PORTS-1:0]             reqValid,
  input  logic [NUM_PORTS-1:0][PageW-1:0]  reqPage,
  input  logic [NUM_PORTS-1:0]             reqWrite,
  input  logic [NUM_PORTS-1:0][ID_W-1:0]   reqId,
  output logic [NUM_PORTS-1:0]             rspValid,
  output logic [NUM_PORTS-1:0]             rspAllow,
  output logic [NUM_PORTS-1:0][IDXW-1:0]   rspRegion,
  output logic [NUM_PORTS-1:0][ID_W-1:0]   rspId
);

  logic [NUM_REGIONS-1:0][31:0] shStart, shEnd, actStart, actEnd;
  logic [NUM_REGIONS-1:0][1:0]  shRights, actRights;
  logic [1:0]                   actShift;

  logic [NUM_PORTS-1:0][IDXW-1:0] winIdx;
  logic [NUM_PORTS-1:0]           allowNow;

  // Shadow set: written by configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shStart  <= '0;
      shEnd    <= '0;
      shRights <= '0;
    end else if (strb.shadowWr) begin
      for (int i = 0; i < NUM_REGIONS; i++) begin
        if (strb.region == CfgRegionW'(i)) begin
          case (strb.field)
            FLD_START:  shStart[i]  <= strb.data;
            FLD_END:    shEnd[i]    <= strb.data;
            FLD_RIGHTS: shRights[i] <= strb.data[1:0];
            default:    ;
          endcase
        end
      end
    end
  end

  // Active set: whole-set copy on commit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actStart  <= '0;
      actEnd    <= '0;
      actRights <= '0;
      actShift  <= '0;
    end else if (strb.commit) begin
      actStart  <= shStart;
      actEnd    <= shEnd;
      actRights <= shRights;
      actShift  <= strb.shift;
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    region_fw_port_check #(
      .NUM_REGIONS (NUM_REGIONS),
      .PORT        (p),
      .IDXW        (IDXW)
    ) u_check (
      .clk       (clk),
      .rstN      (rstN),
      .actStart  (actStart),
      .actEnd    (actEnd),
      .actRights (actRights),
      .actShift  (actShift),
      .reqPage   (reqPage[p]),
      .reqWrite  (reqWrite[p]),
      .winIdx    (winIdx[p]),
      .allow     (allowNow[p])
    );

    AST_RSP_TRACKS_REQ: assert property (@(posedge clk) disable iff (!rstN)
      reqValid[p] |=> rspValid[p]); // R1
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rstN)
      !reqValid[p] |=> (!rspValid[p] && !rspAllow[p])); // R1
  end

  // Result stage
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rspValid  <= '0;
      rspAllow  <= '0;
      rspRegion <= '0;
      rspId     <= '0;
    end else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        rspValid[p] <= reqValid[p];
        rspAllow[p] <= reqValid[p] && allowNow[p];
        if (reqValid[p]) begin
          rspRegion[p] <= winIdx[p];
          rspId[p]     <= reqId[p];
        end
      end
    end
  end

  AST_ACTIVE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> ($stable(actStart) && $stable(actEnd) &&
                      $stable(actRights) && $stable(actShift))); // R8
  AST_SHADOW_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !strb.shadowWr |=> ($stable(shStart) && $stable(shEnd) &&
                        $stable(shRights))); // R8

endmodule

// File: rtl/region_firewall.sv
module region_firewall
  import region_fw_pkg::*;
#(
  parameter int unsigned NUM_REGIONS = 8,
  parameter int unsigned NUM_PORTS   = 2,
  parameter int unsigned ID_W        = 4,
  localparam int unsigned IDXW       = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        cfgWrEn,
  input  logic [5:0]                  cfgAddr,
  input  logic [31:0]                 cfgWrData,
  input  logic [NUM_PORTS-1:0]        reqValid,
  input  logic [NUM_PORTS*PageW-1:0]  reqPage,
  input  logic [NUM_PORTS-1:0]        reqWrite,
  input  logic [NUM_PORTS*ID_W-1:0]   reqId,
  output logic [NUM_PORTS-1:0]        rspValid,
  output logic [NUM_PORTS-1:0]        rspAllow,
  output logic [NUM_PORTS*IDXW-1:0]   rspRegion,
  output logic [NUM_PORTS*ID_W-1:0]   rspId
);

  fwStrobes_t strb;

  logic [NUM_PORTS-1:0][PageW-1:0] reqPageArr;
  logic [NUM_PORTS-1:0][ID_W-1:0]  reqIdArr;
  logic [NUM_PORTS-1:0][IDXW-1:0]  rspRegionArr;
  logic [NUM_PORTS-1:0][ID_W-1:0]  rspIdArr;

  assign reqPageArr = reqPage;
  assign reqIdArr   = reqId;
  assign rspRegion  = rspRegionArr;
  assign rspId      = rspIdArr;

  region_fw_ctrl #(
    .NUM_REGIONS (NUM_REGIONS)
  ) u_ctrl (
    .cfgWrEn   (cfgWrEn),
    .cfgAddr   (cfgAddr),
    .cfgWrData (cfgWrData),
    .strb      (strb)
  );

  region_fw_datapath #(
    .NUM_REGIONS (NUM_REGIONS),
    .NUM_PORTS   (NUM_PORTS),
    .ID_W        (ID_W),
    .IDXW        (IDXW)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqValid  (reqValid),
    .reqPage   (reqPageArr),
    .reqWrite  (reqWrite),
    .reqId     (reqIdArr),
    .rspValid  (rspValid),
    .rspAllow  (rspAllow),
    .rspRegion (rspRegionArr),
    .rspId     (rspIdArr)
  );

endmodule

// File: tb/region_firewall_tb.sv
module region_firewall_tb;

  localparam int NR   = 8;
  localparam int NP   = 2;
  localparam int IDW  = 4;
  localparam int IXW  = 3;
  localparam int PGW  = 22;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              cfgWrEn = 1'b0;
  logic [5:0]        cfgAddr = '0;
  logic [31:0]       cfgWrData = '0;
  logic [NP-1:0]     reqValid = '0;
  logic [NP*PGW-1:0] reqPage = '0;
  logic [NP-1:0]     reqWrite = '0;
  logic [NP*IDW-1:0] reqId = '0;
  logic [NP-1:0]     rspValid;
  logic [NP-1:0]     rspAllow;
  logic [NP*IXW-1:0] rspRegion;
  logic [NP*IDW-1:0] rspId;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  region_firewall #(.NUM_REGIONS(NR), .NUM_PORTS(NP), .ID_W(IDW)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .reqValid(reqValid), .reqPage(reqPage),
    .reqWrite(reqWrite), .reqId(reqId), .rspValid(rspValid),
    .rspAllow(rspAllow), .rspRegion(rspRegion), .rspId(rspId)
  );

  typedef struct packed {
    logic        port;
    logic [33:0] addr;
    logic        wr;
    logic [2:0]  region;
    logic        allow;
    logic [3:0]  req;
  } vec_t;

  localparam int NUM_A = 13;
  localparam int NUM_V = 18;
  localparam vec_t VECS [NUM_V] = '{
    '{1'b0, 34'h0_0000_0000, 1'b0, 3'd0, 1'b1, 4'd2},  // R2 background read
    '{1'b0, 34'h0_0000_0000, 1'b1, 3'd0, 1'b0, 4'd5},  // R5 write denied
    '{1'b0, 34'h0_1000_0000, 1'b0, 3'd1, 1'b1, 4'd6},  // R6 region 5 off on port 0
    '{1'b1, 34'h0_1000_0000, 1'b0, 3'd5, 1'b0, 4'd4},  // R4 region 5 over 1
    '{1'b1, 34'h0_1000_1FFC, 1'b1, 3'd5, 1'b1, 4'd3},  // R3 end inclusive
    '{1'b1, 34'h0_1000_2000, 1'b1, 3'd1, 1'b1, 4'd3},  // R3 just past end
    '{1'b0, 34'h0_1800_0ABC, 1'b0, 3'd2, 1'b0, 4'd4},  // R4 nested region 2
    '{1'b1, 34'h0_1800_0ABC, 1'b0, 3'd1, 1'b1, 4'd6},  // R6 region 2 off on port 1
    '{1'b0, 34'h0_1FFF_FFFF, 1'b1, 3'd1, 1'b1, 4'd3},  // R3 last page of region 1
    '{1'b0, 34'h0_2000_0000, 1'b0, 3'd0, 1'b1, 4'd2},  // R2 above all
    '{1'b0, 34'h0_0FFF_FFFF, 1'b1, 3'd0, 1'b0, 4'd3},  // R3 just below start
    '{1'b0, 34'h3_1000_0000, 1'b0, 3'd1, 1'b1, 4'd3},  // R3 bits 33:32 ignored
    '{1'b0, 34'h0_1800_1000, 1'b0, 3'd1, 1'b1, 4'd3},  // R3 past region 2
    '{1'b0, 34'h3_0000_0000, 1'b1, 3'd3, 1'b1, 4'd7},  // R7 shifted start
    '{1'b0, 34'h3_0000_0FFF, 1'b0, 3'd3, 1'b1, 4'd7},  // R7 shifted end
    '{1'b0, 34'h3_0000_1000, 1'b1, 3'd0, 1'b0, 4'd7},  // R7 past shifted end
    '{1'b0, 34'h0_1000_0000, 1'b1, 3'd0, 1'b0, 4'd7},  // R7 region 1 moved up
    '{1'b0, 34'h0_4000_0000, 1'b1, 3'd1, 1'b1, 4'd7}   // R7 region 1 new start
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [3:0] region, input logic [1:0] field,
                          input logic [31:0] data);
    @(negedge clk);
    cfgWrEn   = 1'b1;
    cfgAddr   = {region, field};
    cfgWrData = data;
    @(negedge clk);
    cfgWrEn   = 1'b0;
  endtask

  task automatic commit(input logic [1:0] shift);
    cfgWrite(4'd0, 2'd3, {30'd0, shift});
  endtask

  // Single-port request; returns {valid, region, allow} sampled one cycle later
  task automatic request(input int port, input logic [33:0] addr, input logic wr,
                         input logic [3:0] id, output logic [4:0] res,
                         output logic [3:0] idOut, output logic otherValid);
    @(negedge clk);
    reqValid = '0;
    reqValid[port] = 1'b1;
    reqPage[port*PGW +: PGW] = addr[33:12];
    reqWrite[port] = wr;
    reqId[port*IDW +: IDW] = id;
    @(negedge clk);
    res = {rspValid[port], rspRegion[port*IXW +: IXW], rspAllow[port]};
    idOut = rspId[port*IDW +: IDW];
    otherValid = rspValid[1-port];
    reqValid = '0;
  endtask

  initial begin
    logic [4:0] res;
    logic [3:0] idOut;
    logic       other;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R9 reset state
    check(rspValid == '0 && rspAllow == '0, "R9 idle after reset",
          {rspValid, rspAllow}, 0);
    request(0, 34'h0_1000_0000, 1'b0, 4'h9, res, idOut, other);
    check(res == {1'b1, 3'd0, 1'b0}, "R9 deny by empty region 0", res, {1'b1, 3'd0, 1'b0});
    // R1 no response in the idle cycle after
    @(negedge clk);
    check(rspValid == '0 && rspAllow == '0, "R1 no response without request",
          {rspValid, rspAllow}, 0);

    // Phase A layout, shift 0
    cfgWrite(4'd0, 2'd2, 32'h1);
    cfgWrite(4'd1, 2'd0, 32'h1000_0000);
    cfgWrite(4'd1, 2'd1, 32'h1FFF_F003);
    cfgWrite(4'd1, 2'd2, 32'h3);
    cfgWrite(4'd2, 2'd0, 32'h1800_0000);
    cfgWrite(4'd2, 2'd1, 32'h1800_0001);
    cfgWrite(4'd2, 2'd2, 32'h0);
    cfgWrite(4'd5, 2'd0, 32'h1000_0000);
    cfgWrite(4'd5, 2'd1, 32'h1000_1002);
    cfgWrite(4'd5, 2'd2, 32'h2);
    commit(2'd0);

    // R6 both ports in the same cycle
    @(negedge clk);
    reqValid = 2'b11;
    reqPage  = {22'h10000, 22'h10000};
    reqWrite = 2'b00;
    reqId    = {4'h2, 4'h1};
    @(negedge clk);
    check({rspValid[0], rspRegion[2:0], rspAllow[0]} == {1'b1, 3'd1, 1'b1},
          "R6 dual port0", {rspValid[0], rspRegion[2:0], rspAllow[0]}, {1'b1, 3'd1, 1'b1});
    check({rspValid[1], rspRegion[5:3], rspAllow[1]} == {1'b1, 3'd5, 1'b0},
          "R6 dual port1", {rspValid[1], rspRegion[5:3], rspAllow[1]}, {1'b1, 3'd5, 1'b0});
    check(rspId == {4'h2, 4'h1}, "R1 id echo dual", rspId, {4'h2, 4'h1});
    reqValid = '0;

    for (int i = 0; i < NUM_V; i++) begin
      if (i == NUM_A) begin
        cfgWrite(4'd3, 2'd0, 32'hC000_0000);
        cfgWrite(4'd3, 2'd1, 32'hC000_0003);
        cfgWrite(4'd3, 2'd2, 32'h3);
        commit(2'd2);
      end
      request(int'(VECS[i].port), VECS[i].addr, VECS[i].wr, 4'(i), res, idOut, other);
      if (res != {1'b1, VECS[i].region, VECS[i].allow} || idOut != 4'(i) || other) begin
        checks++;
        fails++;
        $display("FAIL R%0d vector %0d actual=%0h/%0h expected=%0h/%0h", VECS[i].req, i,
                 res, idOut, {1'b1, VECS[i].region, VECS[i].allow}, 4'(i));
      end else begin
        checks++;
      end
    end

    // R8 shadow writes invisible until commit (shift 2 active)
    cfgWrite(4'd4, 2'd0, 32'h0);
    cfgWrite(4'd4, 2'd1, 32'h3);
    cfgWrite(4'd4, 2'd2, 32'h3);
    request(0, 34'h0, 1'b1, 4'h1, res, idOut, other);
    check(res == {1'b1, 3'd0, 1'b0}, "R8 before commit", res, {1'b1, 3'd0, 1'b0});
    commit(2'd2);
    request(0, 34'h0, 1'b1, 4'h1, res, idOut, other);
    check(res == {1'b1, 3'd4, 1'b1}, "R8 after commit", res, {1'b1, 3'd4, 1'b1});
    cfgWrite(4'd4, 2'd0, 32'h0000_0800);
    request(0, 34'h0, 1'b1, 4'h1, res, idOut, other);
    check(res == {1'b1, 3'd4, 1'b1}, "R8 half update hidden", res, {1'b1, 3'd4, 1'b1});
    cfgWrite(4'd4, 2'd0, 32'h0);

    // R10 out-of-range region index ignored
    cfgWrite(4'd12, 2'd2, 32'h0);
    cfgWrite(4'd12, 2'd0, 32'hFFFF_FC00);
    commit(2'd2);
    request(0, 34'h0, 1'b1, 4'h1, res, idOut, other);
    check(res == {1'b1, 3'd4, 1'b1}, "R10 write to region 12 ignored", res, {1'b1, 3'd4, 1'b1});

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule